// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block turns the system clock into a square-wave tone for a piezo buzzer. A two-bit code picks one of four pitches, and a two-bit code picks how the tone is gated. The four gates are a steady tone, a single fixed-length beep, a 10 Hz on/off chirp, and 10 Hz chirps sent in half-second bursts once per second. One level input, `en`, both enables the block and, in single-beep mode, triggers the beep on its rising edge. The output rests low whenever nothing is sounding.

The clock ratios are parameters. `TICK_DIV` gives the clock cycles per millisecond, and `HALF_0`..`HALF_3` give the tone half-periods in clock cycles. Their defaults suit a 16.9344 MHz clock. The gating lengths are set in milliseconds by `PULSE_MS`, `SHOT_MS` and `REST_MS`, and `BURST_PULSES` sets the number of chirps in a burst.

A gate state machine holds the timing. Its states are ST_IDLE (silent, timers cleared), ST_STEADY (steady tone), ST_SHOT (beep sounding), ST_SHOT_DONE (beep finished, waiting for `en` to drop), ST_PULSE_HI (chirp on), ST_PULSE_LO (chirp off) and ST_REST (silent half of a burst second). Its transitions are as follows:
- Any state goes to ST_IDLE when `en` is low or the settings change.
- ST_IDLE goes to ST_STEADY in mode 0, to ST_SHOT on a rising edge of `en` in mode 1, and to ST_PULSE_HI in modes 2 and 3.
- ST_SHOT goes to ST_SHOT_DONE after `SHOT_MS`.
- ST_PULSE_HI goes to ST_PULSE_LO after `PULSE_MS`.
- ST_PULSE_LO goes back to ST_PULSE_HI after `PULSE_MS`. In mode 3, once the last chirp of the burst has ended, it goes to ST_REST instead.
- ST_REST goes to ST_PULSE_HI after `REST_MS`.

Top module: `buzzer_tone_gen`

## Requirements
- R1: After reset, `buzz_out` is 0, and it stays 0 while `en` is 0.
- R2: `freq_sel` gives the tone half-period in clock cycles: code 0 uses `HALF_0` (0.75 kHz), code 1 uses `HALF_1` (1 kHz), code 2 uses `HALF_2` (1.5 kHz) and code 3 uses `HALF_3` (3 kHz). Each time sounding starts from idle, the tone begins with a full high half-period.
- R3: In mode 0 (`mode_sel`=0), the tone sounds on every cycle while `en` is 1. It starts the cycle after the first clock edge that sees `en` high.
- R4: In mode 1, a rising edge of `en` sounds the tone for `SHOT_MS` ms. The output then stays 0 while `en` stays high. A new beep needs `en` to fall and rise again.
- R5: In mode 2, the tone is gated on for `PULSE_MS` ms and then off for `PULSE_MS` ms, repeating, and the pattern starts with the on part.
- R6: In mode 3, each period starts with `BURST_PULSES` on/off chirps of the mode-2 pattern, followed by `REST_MS` ms of silence, repeating.
- R7: When `en` is 0 at a clock edge, `buzz_out` is 0 from that edge on. All gating state is discarded, so re-enabling starts the pattern from its beginning.
- R8: A change of `mode_sel` or `freq_sel` gives one silent cycle, after which the pattern and the tone phase restart from zero. In mode 1, a change ends any beep, and a fresh rising edge of `en` is needed for the next one.
- R9: One millisecond is exactly `TICK_DIV` clock cycles, counted from the edge that leaves ST_IDLE. Every gated interval lasts an exact multiple of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; rising edge triggers the single beep |
| mode_sel | input | 2 | Gating mode: 0 steady, 1 single beep, 2 10 Hz chirp, 3 bursts at 1 Hz |
| freq_sel | input | 2 | Tone pitch code, see R2 |
| buzz_out | output | 1 | Square-wave buzzer drive, low when silent |

## Verification
The stimulus is driven on the falling edge. The first clock edge after `en` rises moves the state machine out of ST_IDLE, and the output follows on that same edge. That sample is index 0, and from then on the tone state at sample k is high when (k / half-period) is even. The gate term is computed from k and from the ms lengths multiplied by `TICK_DIV`. After `en` falls or a setting changes, the output must be 0 at the very next sample, and after a setting change the pattern restarts from index 0 one edge later. The checks therefore compare every sample of each window against this cycle-exact model, with no slack.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        MODE_STEADY  = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_PULSE   = 2'd2,
        MODE_BURST   = 2'd3
    } buzz_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_STEADY    = 3'd1,
        ST_SHOT      = 3'd2,
        ST_SHOT_DONE = 3'd3,
        ST_PULSE_HI  = 3'd4,
        ST_PULSE_LO  = 3'd5,
        ST_REST      = 3'd6
    } gate_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/buzz_tick_gen.sv
module buzz_tick_gen #(
    parameter int TICK_DIV = 16934
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int TDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TDW-1:0] TOP = TDW'(TICK_DIV - 1);

    logic [TDW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || cnt_q == TOP)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = !clear && (cnt_q == TOP);

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R9: ticks are never adjacent when a millisecond spans several cycles
            a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/buzz_tone_osc.sv
module buzz_tone_osc #(
    parameter int HALF_0 = 11290,
    parameter int HALF_1 = 8467,
    parameter int HALF_2 = 5645,
    parameter int HALF_3 = 2822
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] freq_sel,
    output logic       tone
);
    import buzz_pkg::*;

    localparam int MAX_HALF = max2(max2(HALF_0, HALF_1), max2(HALF_2, HALF_3));
    localparam int TW       = $clog2(MAX_HALF + 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] half_m1;
    logic          tone_q;

    always_comb begin
        unique case (freq_sel)
            2'd0:    half_m1 = TW'(HALF_0 - 1);
            2'd1:    half_m1 = TW'(HALF_1 - 1);
            2'd2:    half_m1 = TW'(HALF_2 - 1);
            default: half_m1 = TW'(HALF_3 - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tone_q <= 1'b1;
        end else if (clear) begin
            cnt_q  <= '0;
            tone_q <= 1'b1;
        end else if (cnt_q >= half_m1) begin
            cnt_q  <= '0;
            tone_q <= ~tone_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign tone = tone_q;

    // R2: a new sounding interval starts on the high half of the tone
    a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear) |-> tone_q);

endmodule

// File: rtl/buzz_gate_fsm.sv
module buzz_gate_fsm #(
    parameter int PULSE_MS     = 50,
    parameter int SHOT_MS      = 100,
    parameter int REST_MS      = 500,
    parameter int BURST_PULSES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] mode_sel,
    input  logic       cfg_change,
    input  logic       tick,
    output logic       sounding,
    output logic       idle
);
    import buzz_pkg::*;

    localparam int MAX_MS = max2(max2(PULSE_MS, SHOT_MS), REST_MS);
    localparam int MSW    = $clog2(MAX_MS + 1);
    localparam int PCW    = $clog2(BURST_PULSES + 1);

    gate_state_e    state_q, state_d;
    buzz_mode_e     mode;
    logic [MSW-1:0] ms_q, ms_d, lim_m1;
    logic [PCW-1:0] pulse_q, pulse_d;
    logic           en_q;
    logic           timed;
    logic           phase_end;
    logic           last_pulse;

    assign mode = buzz_mode_e'(mode_sel);

    always_comb begin
        timed  = 1'b1;
        lim_m1 = '0;
        unique case (state_q)
            ST_SHOT:                  lim_m1 = MSW'(SHOT_MS - 1);
            ST_PULSE_HI, ST_PULSE_LO: lim_m1 = MSW'(PULSE_MS - 1);
            ST_REST:                  lim_m1 = MSW'(REST_MS - 1);
            default:                  timed  = 1'b0;
        endcase
    end

    assign phase_end  = timed && tick && (ms_q == lim_m1);
    assign last_pulse = (mode == MODE_BURST) && (pulse_q == PCW'(BURST_PULSES - 1));

    always_comb begin
        state_d = state_q;
        if (!en || cfg_change) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    unique case (mode)
                        MODE_STEADY:  state_d = ST_STEADY;
                        MODE_ONESHOT: if (!en_q) state_d = ST_SHOT;
                        default:      state_d = ST_PULSE_HI;
                    endcase
                end
                ST_STEADY:    state_d = ST_STEADY;
                ST_SHOT:      if (phase_end) state_d = ST_SHOT_DONE;
                ST_SHOT_DONE: state_d = ST_SHOT_DONE;
                ST_PULSE_HI:  if (phase_end) state_d = ST_PULSE_LO;
                ST_PULSE_LO:  if (phase_end) state_d = last_pulse ? ST_REST : ST_PULSE_HI;
                ST_REST:      if (phase_end) state_d = ST_PULSE_HI;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (state_d != state_q)
            ms_d = '0;
        else if (timed && tick)
            ms_d = ms_q + 1'b1;
        else
            ms_d = ms_q;

        if (state_d == ST_IDLE || state_d == ST_REST)
            pulse_d = '0;
        else if (state_q == ST_PULSE_LO && state_d == ST_PULSE_HI && mode == MODE_BURST)
            pulse_d = pulse_q + 1'b1;
        else
            pulse_d = pulse_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ms_q    <= '0;
            pulse_q <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ms_q    <= ms_d;
            pulse_q <= pulse_d;
            en_q    <= en;
        end
    end

    always_comb begin
        idle     = (state_q == ST_IDLE);
        sounding = (state_q == ST_STEADY) || (state_q == ST_SHOT) ||
                   (state_q == ST_PULSE_HI);
    end

    // R8: a settings change always returns the machine to idle
    a_r8_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> (state_q == ST_IDLE));

    // R4: a finished beep does not restart while enable stays high
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHOT_DONE && en && !cfg_change) |=> (state_q == ST_SHOT_DONE));

    // R5: chirp phases never outlast their length
    a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE_HI || state_q == ST_PULSE_LO) |-> (ms_q < MSW'(PULSE_MS)));

    // R6: chirp count within a burst stays below the burst size
    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q < PCW'(BURST_PULSES));

endmodule

// File: rtl/buzzer_tone_gen.sv
module buzzer_tone_gen #(
    parameter int TICK_DIV     = 16934,
    parameter int HALF_0       = 11290,
    parameter int HALF_1       = 8467,
    parameter int HALF_2       = 5645,
    parameter int HALF_3       = 2822,
    parameter int PULSE_MS     = 50,
    parameter int SHOT_MS      = 100,
    parameter int REST_MS      = 500,
    parameter int BURST_PULSES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] mode_sel,
    input  logic [1:0] freq_sel,
    output logic       buzz_out
);
    logic [3:0] cfg_q;
    logic       cfg_change;
    logic       tick;
    logic       tone;
    logic       sounding;
    logic       idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= {mode_sel, freq_sel};
    end

    assign cfg_change = ({mode_sel, freq_sel} != cfg_q);

    buzz_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idle),
        .tick  (tick)
    );

    buzz_tone_osc #(
        .HALF_0 (HALF_0), .HALF_1 (HALF_1), .HALF_2 (HALF_2), .HALF_3 (HALF_3)
    ) u_osc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .freq_sel (freq_sel),
        .tone     (tone)
    );

    buzz_gate_fsm #(
        .PULSE_MS (PULSE_MS), .SHOT_MS (SHOT_MS),
        .REST_MS  (REST_MS),  .BURST_PULSES (BURST_PULSES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode_sel   (mode_sel),
        .cfg_change (cfg_change),
        .tick       (tick),
        .sounding   (sounding),
        .idle       (idle)
    );

    assign buzz_out = sounding & tone;

    // R7: a low enable silences the output from the next edge on
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !buzz_out);

endmodule

// File: tb/buzzer_tone_gen_tb_top.sv
module buzzer_tone_gen_tb_top;

    localparam int TD    = 4;
    localparam int H0    = 8;
    localparam int H1    = 6;
    localparam int H2    = 4;
    localparam int H3    = 2;
    localparam int P     = 50 * TD;
    localparam int SHOTC = 100 * TD;
    localparam int BWIN  = 5 * 2 * P;
    localparam int SEC   = BWIN + 500 * TD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [1:0] freq_sel = 2'd0;
    logic       buzz_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    buzzer_tone_gen #(
        .TICK_DIV (TD), .HALF_0 (H0), .HALF_1 (H1), .HALF_2 (H2), .HALF_3 (H3)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .en (en),
        .mode_sel (mode_sel), .freq_sel (freq_sel), .buzz_out (buzz_out)
    );

    function automatic int half_of(input int code);
        case (code)
            0: return H0;
            1: return H1;
            2: return H2;
            default: return H3;
        endcase
    endfunction

    // mode 4 stands for "must stay silent"
    function automatic bit model(input int mode, input int half, input int k);
        bit tone;
        bit gate;
        int s;
        tone = ((k / half) % 2) == 0;
        case (mode)
            0: gate = 1'b1;
            1: gate = (k < SHOTC);
            2: gate = (k % (2 * P)) < P;
            3: begin
                s = k % SEC;
                gate = (s < BWIN) && ((s % (2 * P)) < P);
            end
            default: gate = 1'b0;
        endcase
        return tone & gate;
    endfunction

    task automatic run_window(input string req, input int mode, input int half,
                              input int k0, input int n);
        int bad = 0;
        int fk = 0;
        bit fa = 0;
        bit fe = 0;
        for (int k = k0; k < k0 + n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (buzz_out !== model(mode, half, k)) begin
                if (bad == 0) begin fk = k; fa = buzz_out; fe = model(mode, half, k); end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: sample %0d actual=%0b expected=%0b (%0d mismatches)",
                     req, fk, fa, fe, bad);
        end
    endtask

    task automatic check_low_next(input string req);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (buzz_out !== 1'b0) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=0", req, buzz_out);
        end
    endtask

    task automatic setup(input int mode, input int fcode);
        @(negedge clk);
        en = 1'b0;
        mode_sel = 2'(mode);
        freq_sel = 2'(fcode);
        repeat (3) @(negedge clk);
        en = 1'b1;
    endtask

    // R1: reset state and silence while disabled
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (buzz_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset actual=%0b expected=0", buzz_out);
        end
        rst_n = 1'b1;
        mode_sel = 2'd0;
        run_window("R1", 4, 1, 0, 20);
    endtask

    // R2, R3: steady tone at every pitch, then R7 disable
    task automatic t_steady;
        for (int f = 0; f < 4; f++) begin
            setup(0, f);
            run_window((f == 0) ? "R3" : "R2", 0, half_of(f), 0, 64);
        end
        en = 1'b0;
        check_low_next("R7");
        run_window("R7", 4, 1, 0, 10);
    endtask

    // R4, R9: single beep, held enable, retrigger, abort by setting change (R8)
    task automatic t_oneshot;
        setup(1, 2);
        run_window("R9", 1, H2, 0, SHOTC);
        run_window("R4", 1, H2, SHOTC, 600);
        en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        run_window("R4", 1, H2, 0, 500);
        en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        run_window("R4", 1, H2, 0, 200);
        freq_sel = 2'd3;
        check_low_next("R8");
        run_window("R8", 4, 1, 0, 300);
    endtask

    // R5: 10 Hz chirp, then R8 restart on pitch change
    task automatic t_pulse;
        setup(2, 2);
        run_window("R5", 2, H2, 0, 1000);
        freq_sel = 2'd3;
        check_low_next("R8");
        run_window("R8", 2, H3, 0, 500);
    endtask

    // R6: bursts over two full seconds, then R7 abort and restart
    task automatic t_burst;
        setup(3, 1);
        run_window("R6", 3, H1, 0, 2 * SEC + 400);
        en = 1'b0;
        check_low_next("R7");
        @(negedge clk);
        en = 1'b1;
        run_window("R7", 3, H1, 0, 600);
    endtask

    initial begin
        t_reset();
        t_steady();
        t_oneshot();
        t_pulse();
        t_burst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule